// File: doc/BRIEF.md
# Configurable Logic Macrocell

This block is one cell of a programmable logic fabric. Four sum terms arrive from an array that lies outside the block: `sum_a`, `sum_b`, `sum_c` and `sum_d`. A static configuration word routes each of them to one or more roles: register data, K input, asynchronous preset or reset, register clock, or output enable. The cell holds a single storage bit. That bit behaves as a load (D), toggle (T) or JK flip-flop. It can be clocked by the global system clock or by a sum term, and each cell chooses its own active edge.

The cell has a configurable number of function outputs, two by default. Each output independently shows the stored bit or one of three sum terms passed straight through, so one cell can drive a registered output and a combinational output at the same time. A separate enable output serves the attached pin driver. Global preset, global reset and a global register-type input are shared by all cells. When the configuration allows it, the register-type input switches the cell from load mode to its configured alternate mode while the design runs. This lets a loadable counter load in D mode and count in T or JK mode.

Top module: `logic_macrocell`

## Requirements
- R1: With effective kind code 0 or 3 (load), the stored bit takes `sum_a` at each active clock edge.
- R2: With effective kind code 1 (toggle), the stored bit inverts at an active edge when `sum_a` is 1 and keeps its value when `sum_a` is 0.
- R3: With effective kind code 2 (JK, J = `sum_a`, K = `sum_b`), an active edge holds the bit on 0/0, sets it on 1/0, clears it on 0/1 and inverts it on 1/1.
- R4: Output `fn_out[n]` is selected by `cfg_out_sel[2n+1:2n]`, and each output is selected independently of the others. Code 0 gives the stored bit, code 1 gives `sum_a`, code 2 gives `sum_b` and code 3 gives `sum_c`, all without a clock.
- R5: `oe` follows `sum_d` when `cfg_d_oe` is 1 and is held at 1 when `cfg_d_oe` is 0.
- R6: `cfg_clk_src` selects the register clock: code 1 uses `sum_c`, code 2 uses `sum_d`, and codes 0 and 3 use `clk_sys`. The rising edge is the active edge when `cfg_clk_inv` is 0 and the falling edge when it is 1. Edges on any clock that is not selected have no effect.
- R7: `glb_set`, or `sum_b` when `cfg_b_set` is 1, forces the stored bit to 1 at once, without waiting for a clock, and holds it there across active edges while asserted.
- R8: `rst_n` low, `glb_clr`, or `sum_c` when `cfg_c_clr` is 1, forces the stored bit to 0 at once. A clear beats a simultaneous preset, and the bit reads 0 after reset.
- R9: When `cfg_swap_en` is 1 and `glb_rtype` is 1, the effective kind is `cfg_alt_kind`. Otherwise the effective kind is `cfg_base_kind`, and `glb_rtype` has no effect when `cfg_swap_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Global system clock |
| rst_n | input | 1 | Active-low power-on clear |
| sum_a | input | 1 | Sum term A |
| sum_b | input | 1 | Sum term B |
| sum_c | input | 1 | Sum term C |
| sum_d | input | 1 | Sum term D |
| glb_set | input | 1 | Global asynchronous preset |
| glb_clr | input | 1 | Global asynchronous clear |
| glb_rtype | input | 1 | Global register-type switch |
| cfg_base_kind | input | 2 | Register kind normally used |
| cfg_alt_kind | input | 2 | Register kind used while switched |
| cfg_swap_en | input | 1 | Allows `glb_rtype` to switch the kind |
| cfg_clk_src | input | 2 | Register clock source |
| cfg_clk_inv | input | 1 | Selects the falling edge as the active edge |
| cfg_b_set | input | 1 | Routes sum B to the preset |
| cfg_c_clr | input | 1 | Routes sum C to the clear |
| cfg_d_oe | input | 1 | Routes sum D to the output enable |
| cfg_out_sel | input | 2*NUM_OUT | Per-output source codes |
| fn_out | output | NUM_OUT | Function outputs |
| oe | output | 1 | Output enable for the pin driver |

## Verification
Two pairs of functions in this cell can land in the same instant. The first pair is preset and clear. The bench raises the global preset and global clear together and expects 0, since clear has priority. The second pair is a preset and an active clock edge. The bench holds a preset through a system clock edge while `sum_a` is 0 and expects the bit to stay at 1. It then releases the preset and expects the following edge to load `sum_a` again. A reference model tracks the stored bit across every register kind and every kind switch, and each sampled output is compared against that model.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
   localparam int SEL_W = 2;

   typedef enum logic [1:0] {
      K_LOAD   = 2'd0,
      K_TOGGLE = 2'd1,
      K_JK     = 2'd2,
      K_LOAD2  = 2'd3
   } kind_e;

   typedef enum logic [1:0] {
      CS_SYS  = 2'd0,
      CS_SUMC = 2'd1,
      CS_SUMD = 2'd2,
      CS_SYS2 = 2'd3
   } csrc_e;

   typedef enum logic [1:0] {
      OS_Q = 2'd0,
      OS_A = 2'd1,
      OS_B = 2'd2,
      OS_C = 2'd3
   } osel_e;
endpackage

// File: rtl/lmc_ctrl.sv
module lmc_ctrl
   import lmc_pkg::*;
(
   input  logic  clk_sys,
   input  logic  rst_n,
   input  logic  sum_b,
   input  logic  sum_c,
   input  logic  sum_d,
   input  logic  glb_set,
   input  logic  glb_clr,
   input  logic  glb_rtype,
   input  kind_e cfg_base,
   input  kind_e cfg_alt,
   input  logic  cfg_swap,
   input  csrc_e cfg_src,
   input  logic  cfg_inv,
   input  logic  cfg_b_set,
   input  logic  cfg_c_clr,
   input  logic  cfg_d_oe,
   output logic  reg_clk,
   output logic  set_any,
   output logic  clr_any,
   output kind_e eff_kind,
   output logic  oe
);
   logic raw_clk;

   always_comb begin
      unique case (cfg_src)
         CS_SUMC: raw_clk = sum_c;
         CS_SUMD: raw_clk = sum_d;
         default: raw_clk = clk_sys;
      endcase
   end

   assign reg_clk  = raw_clk ^ cfg_inv;
   assign set_any  = glb_set | (cfg_b_set & sum_b);
   assign clr_any  = ~rst_n | glb_clr | (cfg_c_clr & sum_c);
   assign eff_kind = (cfg_swap && glb_rtype) ? cfg_alt : cfg_base;
   assign oe       = cfg_d_oe ? sum_d : 1'b1;
endmodule

// File: rtl/lmc_nextstate.sv
module lmc_nextstate
   import lmc_pkg::*;
#(
   parameter bit HAS_JK = 1'b1
) (
   input  kind_e kind,
   input  logic  q,
   input  logic  j,
   input  logic  k,
   output logic  nxt
);
   logic jk_nxt;

   generate
      if (HAS_JK) begin : g_jk
         assign jk_nxt = (j & ~q) | (~k & q);
      end else begin : g_no_jk
         logic k_unused;
         assign k_unused = k;
         assign jk_nxt   = q ^ j;
      end
   endgenerate

   always_comb begin
      unique case (kind)
         K_TOGGLE: nxt = q ^ j;
         K_JK:     nxt = jk_nxt;
         default:  nxt = j;
      endcase
   end

   always_comb begin
      if (kind == K_TOGGLE && !j)
         AST_T_HOLD: assert (nxt == q) else $error("toggle hold broken"); // R2
      if (HAS_JK && kind == K_JK && j && !k)
         AST_JK_SET: assert (nxt) else $error("jk set broken"); // R3
   end
endmodule

// File: rtl/lmc_outmux.sv
module lmc_outmux
   import lmc_pkg::*;
#(
   parameter int NUM_OUT = 2,
   localparam int SEL_TOT = NUM_OUT * SEL_W
) (
   input  logic [SEL_TOT-1:0] sel,
   input  logic               q,
   input  logic               a,
   input  logic               b,
   input  logic               c,
   output logic [NUM_OUT-1:0] out
);
   generate
      for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
         osel_e code;
         assign code = osel_e'(sel[g*SEL_W +: SEL_W]);
         always_comb begin
            unique case (code)
               OS_A:    out[g] = a;
               OS_B:    out[g] = b;
               OS_C:    out[g] = c;
               default: out[g] = q;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/logic_macrocell.sv
module logic_macrocell
   import lmc_pkg::*;
#(
   parameter int NUM_OUT = 2,
   parameter bit HAS_JK  = 1'b1,
   localparam int SEL_TOT = NUM_OUT * SEL_W
) (
   input  logic               clk_sys,
   input  logic               rst_n,
   input  logic               sum_a,
   input  logic               sum_b,
   input  logic               sum_c,
   input  logic               sum_d,
   input  logic               glb_set,
   input  logic               glb_clr,
   input  logic               glb_rtype,
   input  logic [1:0]         cfg_base_kind,
   input  logic [1:0]         cfg_alt_kind,
   input  logic               cfg_swap_en,
   input  logic [1:0]         cfg_clk_src,
   input  logic               cfg_clk_inv,
   input  logic               cfg_b_set,
   input  logic               cfg_c_clr,
   input  logic               cfg_d_oe,
   input  logic [SEL_TOT-1:0] cfg_out_sel,
   output logic [NUM_OUT-1:0] fn_out,
   output logic               oe
);
   generate
      if (NUM_OUT < 1 || NUM_OUT > 8) begin : g_bad_nout
         $error("NUM_OUT must lie in 1..8");
      end
   endgenerate

   logic  reg_clk;
   logic  set_any;
   logic  clr_any;
   kind_e eff_kind;
   logic  nxt;
   logic  q;

   lmc_ctrl u_ctrl (
      .clk_sys   (clk_sys),
      .rst_n     (rst_n),
      .sum_b     (sum_b),
      .sum_c     (sum_c),
      .sum_d     (sum_d),
      .glb_set   (glb_set),
      .glb_clr   (glb_clr),
      .glb_rtype (glb_rtype),
      .cfg_base  (kind_e'(cfg_base_kind)),
      .cfg_alt   (kind_e'(cfg_alt_kind)),
      .cfg_swap  (cfg_swap_en),
      .cfg_src   (csrc_e'(cfg_clk_src)),
      .cfg_inv   (cfg_clk_inv),
      .cfg_b_set (cfg_b_set),
      .cfg_c_clr (cfg_c_clr),
      .cfg_d_oe  (cfg_d_oe),
      .reg_clk   (reg_clk),
      .set_any   (set_any),
      .clr_any   (clr_any),
      .eff_kind  (eff_kind),
      .oe        (oe)
   );

   lmc_nextstate #(.HAS_JK(HAS_JK)) u_next (
      .kind (eff_kind),
      .q    (q),
      .j    (sum_a),
      .k    (sum_b),
      .nxt  (nxt)
   );

   always_ff @(posedge reg_clk or posedge clr_any or posedge set_any) begin
      if (clr_any)      q <= 1'b0;
      else if (set_any) q <= 1'b1;
      else              q <= nxt;
   end

   lmc_outmux #(.NUM_OUT(NUM_OUT)) u_outmux (
      .sel (cfg_out_sel),
      .q   (q),
      .a   (sum_a),
      .b   (sum_b),
      .c   (sum_c),
      .out (fn_out)
   );

   AST_CLR_WINS: assert property (@(posedge clk_sys) disable iff (!rst_n)
      clr_any |-> !q) else $error("clear did not force zero"); // R8
   AST_SET_HOLD: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (set_any && !clr_any) |-> q) else $error("preset did not force one"); // R7
   AST_OE_DEFAULT: assert property (@(posedge clk_sys) disable iff (!rst_n)
      !cfg_d_oe |-> oe) else $error("enable not held high"); // R5
   AST_OUT_A: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (cfg_out_sel[1:0] == 2'd1) |-> (fn_out[0] == sum_a)) else $error("output 0 not sum A"); // R4
endmodule

// File: tb/logic_macrocell_tb.sv
`timescale 1ns/100ps
module logic_macrocell_tb;
   logic clk_sys = 1'b0;
   always #2 clk_sys = ~clk_sys;

   logic rst_n = 1'b0;
   logic sum_a = 0, sum_b = 0, sum_c = 0, sum_d = 0;
   logic glb_set = 0, glb_clr = 0, glb_rtype = 0;
   logic [1:0] cfg_base_kind = 0, cfg_alt_kind = 0, cfg_clk_src = 0;
   logic cfg_swap_en = 0, cfg_clk_inv = 0, cfg_b_set = 0, cfg_c_clr = 0, cfg_d_oe = 0;
   logic [3:0] cfg_out_sel = 4'b0100;
   logic [1:0] fn_out;
   logic oe;

   int total = 0;
   int bad = 0;
   logic mq = 1'b0;

   logic_macrocell u_dut (
      .clk_sys(clk_sys), .rst_n(rst_n),
      .sum_a(sum_a), .sum_b(sum_b), .sum_c(sum_c), .sum_d(sum_d),
      .glb_set(glb_set), .glb_clr(glb_clr), .glb_rtype(glb_rtype),
      .cfg_base_kind(cfg_base_kind), .cfg_alt_kind(cfg_alt_kind),
      .cfg_swap_en(cfg_swap_en), .cfg_clk_src(cfg_clk_src),
      .cfg_clk_inv(cfg_clk_inv), .cfg_b_set(cfg_b_set),
      .cfg_c_clr(cfg_c_clr), .cfg_d_oe(cfg_d_oe),
      .cfg_out_sel(cfg_out_sel), .fn_out(fn_out), .oe(oe)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic model(input int kind, input logic q, input logic a, input logic b);
      case (kind)
         1: return q ^ a;
         2: return (a & ~q) | (~b & q);
         default: return a;
      endcase
   endfunction

   task automatic step(input logic a, input logic b, input logic rt, input int kind, input string req);
      @(negedge clk_sys);
      sum_a = a; sum_b = b; glb_rtype = rt;
      mq = model(kind, mq, a, b);
      @(posedge clk_sys); #1;
      chk(fn_out[0] === mq, req, fn_out[0], mq);
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #400000;
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk_sys);
      #1;
      chk(fn_out[0] === 1'b0, "R8 reset", fn_out[0], 0);
      chk(oe === 1'b1, "R5 reset", oe, 1);
      @(negedge clk_sys); rst_n = 1'b1; mq = 1'b0;

      // R1 R2 R3: sweep every kind code with mixed input patterns
      for (int k = 0; k < 4; k++) begin
         @(negedge clk_sys); cfg_base_kind = 2'(k);
         for (int i = 0; i < 16; i++) begin
            logic a, b;
            a = 1'(i) ^ 1'(i >> 3);
            b = 1'(i >> 1) ^ 1'(i >> 2);
            step(a, b, 1'b0, k, (k == 1) ? "R2" : (k == 2) ? "R3" : "R1");
         end
      end

      // R9: dynamic switch load<->toggle, load<->JK, then switch disabled
      @(negedge clk_sys); cfg_base_kind = 2'd0; cfg_swap_en = 1'b1;
      for (int alt = 1; alt < 3; alt++) begin
         cfg_alt_kind = 2'(alt);
         for (int i = 0; i < 16; i++) begin
            logic rt;
            rt = 1'(i >> 2);
            step(1'(i) | 1'(i >> 3), 1'(i >> 1), rt, rt ? alt : 0, "R9");
         end
      end
      @(negedge clk_sys); cfg_swap_en = 1'b0; cfg_alt_kind = 2'd1;
      for (int i = 0; i < 8; i++) step(1'(i), 1'(i >> 1), 1'b1, 0, "R9 disabled");
      @(negedge clk_sys); glb_rtype = 1'b0;

      // R4: every select pair over every sum combination
      for (int s0 = 0; s0 < 4; s0++) begin
         for (int s1 = 0; s1 < 4; s1++) begin
            for (int v = 0; v < 8; v++) begin
               logic [3:0] src;
               @(negedge clk_sys);
               cfg_out_sel = {2'(s1), 2'(s0)};
               sum_a = 1'(v); sum_b = 1'(v >> 1); sum_c = 1'(v >> 2);
               #1;
               src = {sum_c, sum_b, sum_a, mq};
               chk(fn_out[0] === src[s0], "R4 out0", fn_out[0], src[s0]);
               chk(fn_out[1] === src[s1], "R4 out1", fn_out[1], src[s1]);
               mq = sum_a;
            end
         end
      end
      @(negedge clk_sys); cfg_out_sel = 4'b0100; sum_c = 0;
      mq = sum_a;

      // R5: enable routing
      cfg_d_oe = 1'b1; sum_d = 1'b0; #1;
      chk(oe === 1'b0, "R5 sumd0", oe, 0);
      sum_d = 1'b1; #1;
      chk(oe === 1'b1, "R5 sumd1", oe, 1);
      cfg_d_oe = 1'b0; sum_d = 1'b0; #1;
      chk(oe === 1'b1, "R5 fixed", oe, 1);

      // R7: preset through sum B, held across a clock edge
      step(1'b0, 1'b0, 1'b0, 0, "R1 pre");
      @(negedge clk_sys); cfg_b_set = 1'b1;
      @(posedge clk_sys); #0.5; sum_b = 1'b1; #0.5;
      chk(fn_out[0] === 1'b1, "R7 sumb immediate", fn_out[0], 1);
      @(posedge clk_sys); #1;
      chk(fn_out[0] === 1'b1, "R7 over edge", fn_out[0], 1);
      @(negedge clk_sys); sum_b = 1'b0;
      @(posedge clk_sys); #1;
      chk(fn_out[0] === 1'b0, "R7 release", fn_out[0], 0);
      @(negedge clk_sys); cfg_b_set = 1'b0; sum_b = 1'b1; #1;
      chk(fn_out[0] === 1'b0, "R7 unrouted", fn_out[0], 0);
      sum_b = 1'b0;
      @(posedge clk_sys); #0.5; glb_set = 1'b1; #0.5;
      chk(fn_out[0] === 1'b1, "R7 global", fn_out[0], 1);
      @(negedge clk_sys); glb_set = 1'b0; sum_a = 1'b1; mq = 1'b1;

      // R8: clear through sum C, global clear, clear beats preset
      @(posedge clk_sys); #1;
      @(negedge clk_sys); cfg_c_clr = 1'b1; sum_c = 1'b1; #0.5;
      chk(fn_out[0] === 1'b0, "R8 sumc", fn_out[0], 0);
      sum_c = 1'b0; cfg_c_clr = 1'b0;
      @(posedge clk_sys); #1;
      chk(fn_out[0] === 1'b1, "R8 reload", fn_out[0], 1);
      #0.5; glb_clr = 1'b1; #0.5;
      chk(fn_out[0] === 1'b0, "R8 global", fn_out[0], 0);
      glb_clr = 1'b0;
      @(posedge clk_sys); #1;
      glb_set = 1'b1; glb_clr = 1'b1; #0.5;
      chk(fn_out[0] === 1'b0, "R8 clear wins", fn_out[0], 0);
      glb_set = 1'b0; glb_clr = 1'b0;

      // R6: clock from sum C, both polarities, then sum D
      @(negedge clk_sys); sum_a = 1'b1; sum_c = 1'b0; cfg_clk_src = 2'd1; #0.5;
      glb_clr = 1'b1; #0.5; glb_clr = 1'b0;
      @(posedge clk_sys); @(posedge clk_sys); #1;
      chk(fn_out[0] === 1'b0, "R6 sys ignored", fn_out[0], 0);
      sum_c = 1'b1; #1;
      chk(fn_out[0] === 1'b1, "R6 sumc rise", fn_out[0], 1);
      sum_a = 1'b0; #0.5; sum_c = 1'b0; #1;
      chk(fn_out[0] === 1'b1, "R6 sumc fall idle", fn_out[0], 1);
      sum_c = 1'b1; #1;
      chk(fn_out[0] === 1'b0, "R6 sumc rise2", fn_out[0], 0);
      cfg_clk_inv = 1'b1; #0.5;
      sum_a = 1'b1; #0.5; sum_c = 1'b0; #1;
      chk(fn_out[0] === 1'b1, "R6 inverted fall", fn_out[0], 1);
      sum_a = 1'b0; #0.5; sum_c = 1'b1; #1;
      chk(fn_out[0] === 1'b1, "R6 inverted rise idle", fn_out[0], 1);
      sum_d = 1'b0; cfg_clk_src = 2'd2; cfg_clk_inv = 1'b0; #1;
      sum_c = 1'b0; #0.5; sum_c = 1'b1; #1;
      chk(fn_out[0] === 1'b1, "R6 sumc unselected", fn_out[0], 1);
      sum_d = 1'b1; #1;
      chk(fn_out[0] === 1'b0, "R6 sumd rise", fn_out[0], 0);
      sum_c = 1'b0;
      @(negedge clk_sys);
      finish_run();
   end
endmodule